// File: doc/BRIEF.md
# Serial Autobaud Detector with Acknowledge

This block finds the bit rate of a serial host by timing one known byte on the receive line. The host sends the byte 0x80 in 8N1 framing, least significant bit first. The start bit and the seven low data bits form one low pulse that lasts eight bit periods. The line then rises at the last data bit.

A timer runs during that pulse. It advances once every eight system clocks and gives a 16-bit measurement. From this measurement the block derives two settings for a baud generator whose prescaler is fixed at one: an integer reload and a five-bit fractional step. One oversample tick then lasts one sixteenth of the measured value.

Once these settings are loaded, the block raises a lock flag. It then sends the byte 0x55 back to the host on its transmit line at the derived rate. The block does not judge whether the measurement was good. After the acknowledge it stays locked and ignores the receive line until the next reset.

Top module: `autobaud_detect`

## Requirements
- R1: While reset is held and just after it is released, `locked` is 0, `txOut` is 1, and `timerVal`, `brInt` and `fracSel` are all zero.
- R2: The receive line first passes through a two-flop synchroniser. If the synchronised line stays low for D clocks, from a falling edge to the next rising edge, the latched `timerVal` is floor(D/8). A test byte with a bit period of P clocks therefore yields P.
- R3: If the timer would step past its maximum value before the rising edge arrives, the measurement is dropped. `locked` stays 0 and nothing is sent. The next falling edge starts a fresh measurement, which behaves as in R2.
- R4: `brInt` equals `timerVal` shifted right by four. If that value does not fit in the reload width, `brInt` saturates to all ones.
- R5: `fracSel` equals the low four bits of `timerVal` with a zero appended as the new least significant bit. That is, `fracSel` = 2 x (`timerVal` mod 16).
- R6: `locked` rises when the rising edge ends a measurement. From then on, `timerVal`, `brInt` and `fracSel` do not change.
- R7: After locking, the block sends exactly one frame: a low start bit, then 0x55 least significant bit first, then a high stop bit.
- R8: Each transmitted bit lasts 16 oversample ticks. A tick lasts max(`brInt`,1) clocks, plus one clock whenever a five-bit accumulator that adds `fracSel` at every tick carries out. As a result, the rising edge that starts data bit 1 and the rising edge that starts the stop bit are exactly 8 x (16 x `brInt` + `fracSel`/2) clocks apart.
- R9: Once `locked` is 1, it stays 1. Further activity on `rxIn` changes no output and sends no frame. Only a reset restarts detection.
- R10: `txOut` is 1 whenever `locked` is 0, and it returns to 1 after the acknowledge frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxIn | input | 1 | Raw serial receive line from the host |
| timerVal | output | CNT_W (16) | Latched measurement of the eight-bit-period low pulse |
| brInt | output | BR_W (11) | Integer reload for the baud generator |
| fracSel | output | 5 | Fractional step for the baud generator, in 1/32 units |
| locked | output | 1 | The divider settings are loaded and valid |
| txOut | output | 1 | Serial transmit line that carries the acknowledge |

## Verification
On every cycle, the assertions check several relations between the outputs. `fracSel` and `brInt` must stay consistent with `timerVal` (fraction and saturation). The lock must be sticky, and the divider outputs must hold once locked. The transmit line must stay idle while unlocked.

Other behaviours only the bench scenarios can show. These are the measured count for a given pulse length, the drop and rearm after a timer overflow, the content of the acknowledge frame, and the exact bit spacing that the fractional accumulator produces. The bench checks these against host bit periods with zero and non-zero fractions, a saturated reload, and traffic that arrives after lock.

// File: rtl/abd_pkg.sv
package abd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MEAS,
    ST_SEND,
    ST_DONE
  } abdState_e;

  // Strobes from control to the datapath
  typedef struct packed {
    logic clrMeas;
    logic runMeas;
    logic loadDiv;
    logic txRun;
  } abdStrobe_t;

  // Events from the datapath back to control
  typedef struct packed {
    logic fallEdge;
    logic riseEdge;
    logic cntOvf;
    logic txDone;
  } abdStatus_t;

endpackage

// File: rtl/abd_ctrl.sv
module abd_ctrl
  import abd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  abdStatus_t stat,
  output abdStrobe_t strobe
);

  abdState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (stat.fallEdge) stateD = ST_MEAS;
      ST_MEAS: begin
        // a closing edge wins over a simultaneous overflow
        if (stat.riseEdge)    stateD = ST_SEND;
        else if (stat.cntOvf) stateD = ST_IDLE;
      end
      ST_SEND: if (stat.txDone) stateD = ST_DONE;
      ST_DONE: stateD = ST_DONE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.clrMeas = (stateQ == ST_IDLE);
    strobe.runMeas = (stateQ == ST_MEAS);
    strobe.loadDiv = (stateQ == ST_MEAS) && stat.riseEdge;
    strobe.txRun   = (stateQ == ST_SEND);
  end

endmodule

// File: rtl/abd_meas.sv
module abd_meas
  import abd_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BR_W    = 11,
  parameter int PRE_DIV = 8,
  parameter int OSR_LOG = 4,
  localparam int FD_W   = OSR_LOG + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  abdStrobe_t       strobe,
  output logic             fallEdge,
  output logic             riseEdge,
  output logic             cntOvf,
  output logic [CNT_W-1:0] timerVal,
  output logic [BR_W-1:0]  brInt,
  output logic [FD_W-1:0]  fracSel,
  output logic             locked
);

  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST  = PRE_W'(PRE_DIV - 1);
  localparam logic [PRE_W-1:0] PRE_FIRST = PRE_W'(1);
  localparam int HI_W = CNT_W - OSR_LOG;

  logic [1:0]       syncQ;
  logic             lineQ;
  logic [PRE_W-1:0] preQ;
  logic [CNT_W-1:0] cntQ;
  logic [BR_W-1:0]  brNext;
  logic [FD_W-1:0]  fdNext;
  logic [CNT_W-1:0] timerQ;
  logic [BR_W-1:0]  brQ;
  logic [FD_W-1:0]  fdQ;
  logic             lockQ;

  // two-flop synchroniser plus one delayed copy for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= 2'b11;
      lineQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rxIn};
      lineQ <= syncQ[1];
    end
  end

  assign fallEdge = lineQ & ~syncQ[1];
  assign riseEdge = ~lineQ & syncQ[1];

  // prescaled timer; prescaler preloads to one so the count is floor(D/PRE_DIV)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ <= '0;
      cntQ <= '0;
    end else if (strobe.clrMeas) begin
      preQ <= PRE_FIRST;
      cntQ <= '0;
    end else if (strobe.runMeas && !riseEdge) begin
      preQ <= preQ + PRE_W'(1);
      if (preQ == PRE_LAST) cntQ <= cntQ + CNT_W'(1);
    end
  end

  assign cntOvf = strobe.runMeas && (preQ == PRE_LAST) && (&cntQ);

  // integer reload: count / OSR, saturated when it does not fit
  generate
    if (HI_W > BR_W) begin : g_sat
      logic [HI_W-1:0] hiBits;
      assign hiBits = cntQ[CNT_W-1:OSR_LOG];
      assign brNext = (|hiBits[HI_W-1:BR_W]) ? '1 : hiBits[BR_W-1:0];
    end else begin : g_ext
      assign brNext = BR_W'(cntQ[CNT_W-1:OSR_LOG]);
    end
  endgenerate

  assign fdNext = {cntQ[OSR_LOG-1:0], 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ <= '0;
      brQ    <= '0;
      fdQ    <= '0;
      lockQ  <= 1'b0;
    end else if (strobe.loadDiv) begin
      timerQ <= cntQ;
      brQ    <= brNext;
      fdQ    <= fdNext;
      lockQ  <= 1'b1;
    end
  end

  assign timerVal = timerQ;
  assign brInt    = brQ;
  assign fracSel  = fdQ;
  assign locked   = lockQ;

endmodule

// File: rtl/abd_tx.sv
module abd_tx #(
  parameter int BR_W           = 11,
  parameter int OSR_LOG        = 4,
  parameter logic [7:0] ACK_BYTE = 8'h55,
  localparam int FD_W          = OSR_LOG + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            txRun,
  input  logic [BR_W-1:0] brInt,
  input  logic [FD_W-1:0] fracSel,
  output logic            txDone,
  output logic            txOut
);

  localparam int FRAME_LEN = 10;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [FRAME_LEN-1:0] FRAME = {1'b1, ACK_BYTE, 1'b0};
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_LEN - 1);

  logic [BR_W-1:0]    tickCntQ;
  logic [FD_W-1:0]    accQ;
  logic [OSR_LOG-1:0] osQ;
  logic [IDX_W-1:0]   idxQ;
  logic [FD_W:0]      accSum;
  logic [BR_W-1:0]    brEff;
  logic [BR_W-1:0]    reload;
  logic               tick;
  logic               bitEnd;

  assign tick   = txRun && (tickCntQ == '0);
  assign accSum = {1'b0, accQ} + {1'b0, fracSel};
  assign brEff  = (brInt == '0) ? BR_W'(1) : brInt;
  assign reload = brEff - BR_W'(1) + BR_W'(accSum[FD_W]);
  assign bitEnd = tick && (&osQ);
  assign txDone = bitEnd && (idxQ == IDX_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCntQ <= '0;
      accQ     <= '0;
      osQ      <= '0;
      idxQ     <= '0;
    end else if (!txRun) begin
      tickCntQ <= '0;
      accQ     <= '0;
      osQ      <= '0;
      idxQ     <= '0;
    end else if (tick) begin
      tickCntQ <= reload;
      accQ     <= accSum[FD_W-1:0];
      osQ      <= osQ + OSR_LOG'(1);
      if (bitEnd) idxQ <= idxQ + IDX_W'(1);
    end else begin
      tickCntQ <= tickCntQ - BR_W'(1);
    end
  end

  assign txOut = txRun ? FRAME[idxQ] : 1'b1;

endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect
  import abd_pkg::*;
#(
  parameter int CNT_W            = 16,
  parameter int BR_W             = 11,
  parameter int PRE_DIV          = 8,
  parameter logic [7:0] ACK_BYTE = 8'h55,
  localparam int OSR_LOG         = 4,
  localparam int FD_W            = OSR_LOG + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  output logic [CNT_W-1:0] timerVal,
  output logic [BR_W-1:0]  brInt,
  output logic [FD_W-1:0]  fracSel,
  output logic             locked,
  output logic             txOut
);

  abdStrobe_t strobe;
  abdStatus_t stat;
  logic       fallEdge, riseEdge, cntOvf, txDone;

  assign stat = '{fallEdge: fallEdge, riseEdge: riseEdge, cntOvf: cntOvf, txDone: txDone};

  abd_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .stat   (stat),
    .strobe (strobe)
  );

  abd_meas #(
    .CNT_W   (CNT_W),
    .BR_W    (BR_W),
    .PRE_DIV (PRE_DIV),
    .OSR_LOG (OSR_LOG)
  ) u_meas (
    .clk      (clk),
    .rstN     (rstN),
    .rxIn     (rxIn),
    .strobe   (strobe),
    .fallEdge (fallEdge),
    .riseEdge (riseEdge),
    .cntOvf   (cntOvf),
    .timerVal (timerVal),
    .brInt    (brInt),
    .fracSel  (fracSel),
    .locked   (locked)
  );

  abd_tx #(
    .BR_W     (BR_W),
    .OSR_LOG  (OSR_LOG),
    .ACK_BYTE (ACK_BYTE)
  ) u_tx (
    .clk     (clk),
    .rstN    (rstN),
    .txRun   (strobe.txRun),
    .brInt   (brInt),
    .fracSel (fracSel),
    .txDone  (txDone),
    .txOut   (txOut)
  );

endmodule

// File: rtl/abd_checker.sv
module abd_checker #(
  parameter int CNT_W = 16,
  parameter int BR_W  = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] timerVal,
  input logic [BR_W-1:0]  brInt,
  input logic [4:0]       fracSel,
  input logic             locked,
  input logic             txOut
);

  localparam int unsigned BR_MAX = (1 << BR_W) - 1;

  int unsigned hiVal;
  int unsigned expBr;

  always_comb begin
    hiVal = int'(timerVal) >> 4;
    expBr = (hiVal > BR_MAX) ? BR_MAX : hiVal;
  end

  // R4
  p_br_sat_r4: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (int'(brInt) == expBr));

  // R5
  p_frac_r5: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (fracSel == {timerVal[3:0], 1'b0}));

  // R6
  p_div_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> ($stable(timerVal) && $stable(brInt) && $stable(fracSel)));

  // R9
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

  // R10
  p_tx_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> txOut);

endmodule

bind autobaud_detect abd_checker #(.CNT_W(CNT_W), .BR_W(BR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .timerVal (timerVal),
  .brInt    (brInt),
  .fracSel  (fracSel),
  .locked   (locked),
  .txOut    (txOut)
);

// File: tb/sim_autobaud_detect.sv
module sim_autobaud_detect;

  localparam int CNT_W  = 12;
  localparam int BR_W   = 6;
  localparam int BR_MAX = (1 << BR_W) - 1;

  logic             clk  = 1'b0;
  logic             rstN = 1'b0;
  logic             rxIn = 1'b1;
  logic [CNT_W-1:0] timerVal;
  logic [BR_W-1:0]  brInt;
  logic [4:0]       fracSel;
  logic             locked;
  logic             txOut;

  autobaud_detect #(.CNT_W(CNT_W), .BR_W(BR_W)) u0 (
    .clk      (clk),
    .rstN     (rstN),
    .rxIn     (rxIn),
    .timerVal (timerVal),
    .brInt    (brInt),
    .fracSel  (fracSel),
    .locked   (locked),
    .txOut    (txOut)
  );

  always #5ns clk = ~clk;

  int     total = 0;
  int     bad   = 0;
  longint cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int ackByte;
    int bitLen;
  } expItem_t;

  expItem_t expQ[$];
  longint   edgeT[$];
  logic     prevTx = 1'b1;

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // transition recorder on the transmit line
  always @(negedge clk) begin
    if (txOut !== prevTx) edgeT.push_back(cyc);
    prevTx = txOut;
  end

  // monitor: decodes each acknowledge frame and compares with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && txOut === 1'b0) begin
        if (expQ.size() == 0) begin
          check("R9", "frame without expectation", 1, 0);
          while (txOut !== 1'b1) @(negedge clk);
        end else begin
          expItem_t it;
          logic [7:0] data;
          it = expQ.pop_front();
          repeat (it.bitLen / 2) @(negedge clk);
          check("R7", "start bit level", int'(txOut), 0);
          for (int i = 0; i < 8; i++) begin
            repeat (it.bitLen) @(negedge clk);
            data[i] = txOut;
          end
          repeat (it.bitLen) @(negedge clk);
          check("R7", "stop bit level", int'(txOut), 1);
          check("R7", "acknowledge byte", int'(data), it.ackByte);
        end
      end
    end
  end

  function automatic int expBr(input int p);
    int hi;
    hi = p >> 4;
    return (hi > BR_MAX) ? BR_MAX : hi;
  endfunction

  function automatic int expFd(input int p);
    return (p % 16) * 2;
  endfunction

  function automatic int expBitLen(input int p);
    return 16 * expBr(p) + (p % 16);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    rxIn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // host side: byte 0x80, 8N1, bit period p clocks
  task automatic driveTestByte(input int p);
    @(negedge clk);
    rxIn = 1'b0;
    repeat (8 * p) @(negedge clk);
    rxIn = 1'b1;
  endtask

  // driver: pushes the expected acknowledge, drives the byte, waits for the frame
  task automatic sendTest(input int p);
    expItem_t it;
    it.ackByte = 8'h55;
    it.bitLen  = expBitLen(p);
    expQ.push_back(it);
    edgeT.delete();
    driveTestByte(p);
    repeat (12 * it.bitLen + 50) @(negedge clk);
  endtask

  task automatic checkLocked(input int p);
    int bl;
    bl = expBitLen(p);
    check("R2", "timer value", int'(timerVal), p);
    check("R4", "integer reload", int'(brInt), expBr(p));
    check("R5", "fraction", int'(fracSel), expFd(p));
    check("R6", "locked", int'(locked), 1);
    check("R7", "transmit transitions", edgeT.size(), 10);
    if (edgeT.size() == 10)
      check("R8", "bit1-to-stop span", int'(edgeT[9] - edgeT[1]), 8 * bl);
    check("R10", "line idle after frame", int'(txOut), 1);
  endtask

  initial begin
    #1_500_000ns;
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state, during and after reset
    repeat (2) @(negedge clk);
    check("R1", "locked in reset", int'(locked), 0);
    check("R1", "tx in reset", int'(txOut), 1);
    doReset();
    check("R1", "locked after reset", int'(locked), 0);
    check("R1", "tx after reset", int'(txOut), 1);
    check("R1", "timer after reset", int'(timerVal), 0);
    check("R1", "reload after reset", int'(brInt), 0);
    check("R1", "fraction after reset", int'(fracSel), 0);

    // whole-number rate: fraction zero path of the generator
    sendTest(100);
    checkLocked(100);

    // R9: later traffic is ignored
    edgeT.delete();
    driveTestByte(60);
    repeat (1500) @(negedge clk);
    check("R9", "timer after extra byte", int'(timerVal), 100);
    check("R9", "reload after extra byte", int'(brInt), expBr(100));
    check("R9", "locked after extra byte", int'(locked), 1);
    check("R9", "no new transmit edges", edgeT.size(), 0);

    // non-zero fraction
    doReset();
    sendTest(37);
    checkLocked(37);

    // R3: timer overflow drops the measurement, then a new one works
    doReset();
    edgeT.delete();
    @(negedge clk);
    rxIn = 1'b0;
    repeat (8 * (1 << CNT_W) + 200) @(negedge clk);
    rxIn = 1'b1;
    repeat (40) @(negedge clk);
    check("R3", "locked after overflow", int'(locked), 0);
    check("R3", "no frame after overflow", edgeT.size(), 0);
    check("R10", "tx idle while unlocked", int'(txOut), 1);
    sendTest(50);
    check("R3", "timer after rearm", int'(timerVal), 50);
    checkLocked(50);

    // R4: saturated reload
    doReset();
    sendTest(1100);
    checkLocked(1100);

    check("R7", "all expected frames seen", expQ.size(), 0);
    summary();
    $finish;
  end

endmodule